// File: doc/BRIEF.md
# Sample Ring Buffer with Host Window

This block holds acquired samples in a circular store that two parties share. A conversion engine pushes 16-bit samples through a valid/ready port, and each accepted sample is written at the front index, which then advances. A host reads samples through a word-addressed port, then writes its new rear index back to free the space it has drained. The store depth is not a power of two, so both indices wrap by compare-and-reset and not by natural overflow.

The block keeps the unread count, which is front minus rear, plus the depth when that difference is negative. It raises sticky flags for three events: the count reaching a programmable threshold, a sample lost because the store was full, and an external hardware fault. A single interrupt line reports whether any flag is set. The host clears flags by writing ones to them.

Producer port rules: `prod_ready` is low only while the store holds depth minus one samples. The conversion engine cannot stall. A beat offered with `prod_valid` high while `prod_ready` is low is lost, and it is recorded as an overrun. No back-pressure reaches further upstream.

Top module: `rb_sample_ring`

## Requirements
- R1: An accepted sample (`prod_valid` and `prod_ready` both high) is stored at the front index. The front index then advances by one and goes from DEPTH-1 to 0. The host reads the front index at register word 0 (address bit 12 = 0, low bits 3'd0).
- R2: Register word 2 reads the unread count. The count is front minus rear, plus DEPTH when the difference is negative.
- R3: `prod_ready` is low exactly when the count equals DEPTH-1. A beat offered while ready is low is discarded, and the front index does not move. Flag bit 1 (overrun) is set at that same clock edge.
- R4: A host read with address bit 12 = 1 returns the sample at index (rear + address[11:0]) mod DEPTH, for offsets below DEPTH. The data appears on `host_rdata` with `host_rvalid` high one cycle after `host_rd`.
- R5: Flag bit 0 (threshold) is set one clock after a cycle in which the count is greater than or equal to the threshold register, which is register word 3.
- R6: Flag bit 2 (hardware fault) is set one clock after a cycle with `hw_fault` high.
- R7: Flags are read at register word 4 and stay set until the host writes a one to that bit. When a set and a clear of the same bit fall in one cycle, the bit stays set.
- R8: A write to register word 1 loads the rear index only if the value is below DEPTH. A larger value leaves the rear index unchanged. Writes to word 0 and word 2 have no effect.
- R9: After reset the front index, rear index, count and flags read 0, the threshold reads DEPTH/2 (1001 at the default depth), and `prod_ready` is high.
- R10: `irq` is high exactly when any flag bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | Producer offers a sample |
| prod_ready | output | 1 | Store has room for a sample |
| prod_data | input | 16 | Sample word |
| hw_fault | input | 1 | Hardware fault indication |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 13 | Bit 12 selects the sample window; bits 11:0 are the offset or the register word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| irq | output | 1 | Any flag set |

## Verification
The front index, the count and `prod_ready` change at the same edge that accepts a sample. Flag bits are registered, so they show the condition seen in the cycle before, and read data arrives one edge after the strobe. The bench keeps a behavioural model that it updates at each rising edge from the inputs that edge sampled, using the state from before that edge. It compares the model with the outputs at the following falling edge. The directed reads leave an idle cycle after a flag-setting event, so that the registered flag has landed before the read strobe is sampled.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [2:0] {
    REG_FRONT  = 3'd0,
    REG_REAR   = 3'd1,
    REG_COUNT  = 3'd2,
    REG_THRESH = 3'd3,
    REG_FLAGS  = 3'd4
  } rb_reg_e;

  localparam int FLAG_W    = 8;
  localparam int FLAG_FULL = 0;
  localparam int FLAG_OVR  = 1;
  localparam int FLAG_HW   = 2;
endpackage

// File: rtl/rb_ptr_ctrl.sv
module rb_ptr_ctrl #(
  parameter int DEPTH  = 2003,
  parameter int WD_W   = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             rear_we,
  input  logic [WD_W-1:0]  rear_wdata,
  output logic [PTR_W-1:0] front,
  output logic [PTR_W-1:0] rear,
  output logic [PTR_W-1:0] count,
  output logic             ready,
  output logic             accept,
  output logic             drop
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // Modular difference: the true value is always below 2**PTR_W
  assign count  = (front >= rear) ? (front - rear) : (front + PTR_W'(DEPTH) - rear);
  assign ready  = (count != LAST);
  assign accept = push & ready;
  assign drop   = push & ~ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front <= '0;
      rear  <= '0;
    end else begin
      if (accept) front <= (front == LAST) ? '0 : front + 1'b1;
      if (rear_we && (rear_wdata < WD_W'(DEPTH))) rear <= PTR_W'(rear_wdata);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST); // R3
  AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(front)); // R3
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (front <= LAST) && (rear <= LAST)); // R1
  AST_REAR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rear_we && rear_wdata >= WD_W'(DEPTH)) |=> $stable(rear)); // R8
endmodule

// File: rtl/rb_flags.sv
module rb_flags #(
  parameter int CNT_W = 11,
  parameter int TH_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         count,
  input  logic [TH_W-1:0]          thresh,
  input  logic                     drop,
  input  logic                     hw_fault,
  input  logic                     clr_we,
  input  logic [2:0]               clr_mask,
  output logic [rb_pkg::FLAG_W-1:0] flags
);
  import rb_pkg::*;

  logic [FLAG_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[FLAG_FULL] = (TH_W'(count) >= thresh);
    set_v[FLAG_OVR]  = drop;
    set_v[FLAG_HW]   = hw_fault;
    clr_v = clr_we ? FLAG_W'(clr_mask) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;
  end

  AST_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (TH_W'(count) >= thresh) |=> flags[FLAG_FULL]); // R5
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flags[FLAG_OVR]); // R3
  AST_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fault |=> flags[FLAG_HW]); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLAG_HW] && !(clr_we && clr_mask[FLAG_HW])) |=> flags[FLAG_HW]); // R7
endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DEPTH  = 2003,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rd_en) rdata <= mem[raddr];
  end

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (raddr < PTR_W'(DEPTH))); // R4
endmodule

// File: rtl/rb_sample_ring.sv
module rb_sample_ring #(
  parameter int DEPTH      = 2003,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 13,
  parameter int THRESH_RST = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_valid,
  output logic              prod_ready,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              hw_fault,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              irq
);
  import rb_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int OFF_W = ADDR_W - 1;
  localparam int SUM_W = ((OFF_W > PTR_W) ? OFF_W : PTR_W) + 1;

  logic [PTR_W-1:0]  front, rear, count, raddr;
  logic              accept, drop, sel_mem, wr_reg, sel_q;
  logic [2:0]        reg_idx;
  logic [OFF_W-1:0]  off;
  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] thresh, reg_q, mem_q;
  logic [FLAG_W-1:0] flags;

  assign sel_mem = host_addr[ADDR_W-1];
  assign reg_idx = host_addr[2:0];
  assign off     = host_addr[OFF_W-1:0];
  assign wr_reg  = host_wr & ~sel_mem;

  rb_ptr_ctrl #(.DEPTH(DEPTH), .WD_W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(prod_valid),
    .rear_we(wr_reg && reg_idx == REG_REAR), .rear_wdata(host_wdata),
    .front(front), .rear(rear), .count(count), .ready(prod_ready),
    .accept(accept), .drop(drop)
  );

  rb_flags #(.CNT_W(PTR_W), .TH_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .thresh(thresh), .drop(drop),
    .hw_fault(hw_fault), .clr_we(wr_reg && reg_idx == REG_FLAGS),
    .clr_mask(host_wdata[2:0]), .flags(flags)
  );

  // Window index: rear plus offset, folded once into range
  assign sum   = SUM_W'(rear) + SUM_W'(off);
  assign raddr = PTR_W'((sum >= SUM_W'(DEPTH)) ? (sum - SUM_W'(DEPTH)) : sum);

  rb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(accept), .waddr(front), .wdata(prod_data),
    .rd_en(host_rd & sel_mem), .raddr(raddr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) thresh <= DATA_W'(THRESH_RST);
    else if (wr_reg && reg_idx == REG_THRESH) thresh <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q       <= '0;
      sel_q       <= 1'b0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        sel_q <= sel_mem;
        case (reg_idx)
          REG_FRONT:  reg_q <= DATA_W'(front);
          REG_REAR:   reg_q <= DATA_W'(rear);
          REG_COUNT:  reg_q <= DATA_W'(count);
          REG_THRESH: reg_q <= thresh;
          REG_FLAGS:  reg_q <= DATA_W'(flags);
          default:    reg_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata = sel_q ? mem_q : reg_q;
  assign irq        = |flags;

  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid); // R4
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLAG_HW]) |-> irq); // R10
endmodule

// File: tb/rb_sample_ring_bench.sv
module rb_sample_ring_bench;
  localparam int PERIOD = 10;
  localparam int D      = 2003;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pv = 1'b0, hw = 1'b0, hwr = 1'b0, hrd = 1'b0;
  logic [15:0] pdata = '0, hwd = '0;
  logic [12:0] haddr = '0;
  logic prdy, rvalid, irq;
  logic [15:0] rdata;

  int n_chk = 0, n_err = 0, seq = 0;
  bit done = 0;

  // behavioural model
  int m_front, m_rear, m_thr, m_flags, m_rdata, m_rvalid;
  int m_mem [D];
  string m_tag;

  always #(PERIOD/2) clk = ~clk;

  rb_sample_ring u_rb_sample_ring (
    .clk(clk), .rst_n(rst_n), .prod_valid(pv), .prod_ready(prdy), .prod_data(pdata),
    .hw_fault(hw), .host_wr(hwr), .host_rd(hrd), .host_addr(haddr),
    .host_wdata(hwd), .host_rdata(rdata), .host_rvalid(rvalid), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int mcount();
    return (m_front - m_rear + D) % D;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_front = 0; m_rear = 0; m_thr = D / 2; m_flags = 0; m_rvalid = 0;
    end else begin
      int cnt, set, clr;
      cnt = mcount();
      set = 0;
      if (cnt >= m_thr) set |= 1;
      if (pv && cnt == D - 1) set |= 2;
      if (hw) set |= 4;
      clr = (hwr && !haddr[12] && haddr[2:0] == 3'd4) ? int'(hwd) & 7 : 0;
      m_rvalid = hrd;
      if (hrd) begin
        if (haddr[12]) begin
          m_rdata = m_mem[(m_rear + int'(haddr[11:0])) % D]; m_tag = "R4";
        end else begin
          case (haddr[2:0])
            3'd0: begin m_rdata = m_front; m_tag = "R1"; end
            3'd1: begin m_rdata = m_rear;  m_tag = "R8"; end
            3'd2: begin m_rdata = cnt;     m_tag = "R2"; end
            3'd3: begin m_rdata = m_thr;   m_tag = "R9"; end
            3'd4: begin m_rdata = m_flags; m_tag = "R7"; end
            default: begin m_rdata = 0;    m_tag = "R8"; end
          endcase
        end
      end
      m_flags = (m_flags & ~clr) | set;
      if (pv && cnt != D - 1) begin
        m_mem[m_front] = int'(pdata);
        m_front = (m_front + 1) % D;
      end
      if (hwr && !haddr[12]) begin
        if (haddr[2:0] == 3'd1 && int'(hwd) < D) m_rear = int'(hwd);
        if (haddr[2:0] == 3'd3) m_thr = int'(hwd);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(prdy == (mcount() != D - 1), "R3", int'(prdy), int'(mcount() != D - 1));
      chk(irq == (m_flags != 0), "R10", int'(irq), int'(m_flags != 0));
      chk(rvalid == m_rvalid[0], "R4", int'(rvalid), m_rvalid);
      if (rvalid) chk(int'(rdata) == m_rdata, m_tag, int'(rdata), m_rdata);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      pv = 1'b1; pdata = 16'(16'h100 + seq); seq++;
      @(negedge clk);
    end
    pv = 1'b0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [15:0] d);
    hwr = 1'b1; haddr = a; hwd = d;
    @(negedge clk);
    hwr = 1'b0;
  endtask

  task automatic rd_exp(input logic [12:0] a, input int exp, input string tag);
    hrd = 1'b1; haddr = a;
    @(negedge clk);
    hrd = 1'b0;
    chk(int'(rdata) == exp, tag, int'(rdata), exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    chk(prdy == 1'b1, "R9", int'(prdy), 1);
    chk(irq == 1'b0, "R9", int'(irq), 0);
    rd_exp(13'd0, 0, "R9");
    rd_exp(13'd1, 0, "R9");
    rd_exp(13'd2, 0, "R9");
    rd_exp(13'd3, 1001, "R9");
    rd_exp(13'd4, 0, "R9");
    // R5 threshold flag
    wr(13'd3, 16'd5);
    push(4);
    idle(1);
    rd_exp(13'd4, 0, "R5");
    push(1);
    idle(1);
    rd_exp(13'd4, 1, "R5");
    chk(irq == 1'b1, "R10", int'(irq), 1);
    // R4 window reads
    for (int i = 0; i < 5; i++) rd_exp(13'h1000 | 13'(i), 16'h100 + i, "R4");
    // R1 / R2 rear update and count
    wr(13'd1, 16'd3);
    rd_exp(13'd2, 2, "R2");
    rd_exp(13'h1000, 16'h103, "R4");
    wr(13'd4, 16'd1);
    rd_exp(13'd4, 0, "R7");
    // R8 ignored writes
    wr(13'd1, 16'd2500);
    rd_exp(13'd1, 3, "R8");
    wr(13'd0, 16'd77);
    wr(13'd2, 16'd9);
    rd_exp(13'd0, 5, "R8");
    // R6 / R7 fault flag, clear losing to set
    hw = 1'b1; @(negedge clk); hw = 1'b0;
    idle(1);
    rd_exp(13'd4, 4, "R6");
    hw = 1'b1; wr(13'd4, 16'd4); hw = 1'b0;
    rd_exp(13'd4, 4, "R7");
    wr(13'd4, 16'd4);
    rd_exp(13'd4, 0, "R7");
    chk(irq == 1'b0, "R10", int'(irq), 0);
    // R3 fill to the limit, then lose one beat; front wraps (R1)
    wr(13'd3, 16'd2002);
    push(2000);
    chk(prdy == 1'b0, "R3", int'(prdy), 0);
    push(1);
    idle(1);
    rd_exp(13'd4, 3, "R3");
    rd_exp(13'd0, 2, "R1");
    rd_exp(13'd2, 2002, "R2");
    rd_exp(13'h1000 | 13'd2001, 2260, "R4");
    rd_exp(13'h1000 | 13'd1999, 2258, "R4");
    // drain
    wr(13'd1, 16'd2);
    rd_exp(13'd2, 0, "R2");
    chk(prdy == 1'b1, "R3", int'(prdy), 1);
    push(3);
    rd_exp(13'd0, 5, "R1");
    rd_exp(13'h1000 | 13'd2, 16'(16'h100 + seq - 1), "R4");
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule